// File: doc/BRIEF.md
# Transmit Character Parity Guard

This block sits in a transmit path just ahead of the serializer. On every character clock it takes a 10-bit character and an odd-parity bit from the user. When parity checking is turned on and the 11 bits together do not hold an odd number of ones, the character is not forwarded. A fixed 10-bit error code is sent in its place, so the receiver at the far end sees an invalid character.

A single status output reports three conditions:
- a one-cycle pulse for each replaced character;
- a one-cycle pulse once per complete pass of the 511-character self-test sequence while self-test is enabled;
- a sticky level after a phase-align buffer fault. The level holds until a word-sync sequence is reported as sent, or until reset is sampled low.

All inputs are sampled on the rising edge of the selected transmit input clock. The character and the status come out of one register stage. Serialization and line coding are outside this block.

Top module: `txParityGuard`

## Requirements
- R1: While rstN is sampled low at a rising edge, the next cycle shows outChar = 0 and errStatus = 0, and any held buffer fault is cleared.
- R2: With parityEn = 1 and an odd number of ones across {inData, inParity}, outChar equals the sampled inData in the cycle after the edge that sampled it.
- R3: With parityEn = 1 and an even number of ones across {inData, inParity}, outChar is 10'b1001111000 (bit 9 on the left) in the cycle after that edge.
- R4: The parity part of errStatus is high for exactly the cycle in which a replaced character is presented, and low otherwise.
- R5: With parityEn = 0, inData passes to outChar unchanged one cycle later, whatever inParity is, and no parity status is raised.
- R6: While bistEn = 1, a one-cycle self-test pulse appears on errStatus after the 511th consecutive enabled edge, and then after every further 511 enabled edges. Sampling bistEn = 0 restarts the count and suppresses the pulse.
- R7: bufFault sampled high sets a held fault that drives errStatus high from the next cycle on. The held fault clears only after syncSent is sampled high or rstN is sampled low.
- R8: If bufFault and syncSent are sampled high at the same edge, the fault is held.
- R9: errStatus is the OR of the parity pulse, the self-test pulse and the held fault.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit input character clock |
| rstN | input | 1 | Synchronous active-low reset |
| inData | input | 10 | Transmit character |
| inParity | input | 1 | Odd-parity bit for inData |
| parityEn | input | 1 | 1 enables checking and replacement |
| bistEn | input | 1 | 1 runs the self-test pass counter |
| bufFault | input | 1 | Phase-align buffer under/overflow pulse |
| syncSent | input | 1 | Word-sync sequence sent pulse |
| outChar | output | 10 | Character to the shifter |
| errStatus | output | 1 | Combined error / self-test / fault status |

## Verification
Each fault shows up at the ports within one or two cycles:
- A wrong parity decision shows as a mismatched outChar or a wrong errStatus in the very next cycle.
- A held-fault register that drops early or never clears gives a wrong errStatus level on the first cycle after a fault or sync pulse.
- A self-test counter with the wrong modulus moves the status pulse away from the expected 511-edge positions. Over a window of more than two full passes, this shows as a missing or extra pulse on the first pass where the counts disagree.

// File: rtl/txpg_pkg.sv
package txpg_pkg;
  // Strobes from the control side to the datapath
  typedef struct packed {
    logic bistMark;   // one-cycle self-test pass marker
    logic faultHeld;  // sticky phase-buffer fault
  } ctlStrobes_t;
endpackage

// File: rtl/txpgCtrl.sv
module txpgCtrl
  import txpg_pkg::*;
#(
  parameter int BIST_LEN = 511
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        bistEn,
  input  logic        bufFault,
  input  logic        syncSent,
  output ctlStrobes_t ctl
);
  localparam int CNT_W = $clog2(BIST_LEN);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BIST_LEN - 1);

  logic [CNT_W-1:0] passCnt;
  logic             bistMark;
  logic             faultHeld;

  // Self-test pass counter: counts enabled edges, wraps after BIST_LEN
  always_ff @(posedge clk) begin
    if (!rstN || !bistEn) begin
      passCnt  <= '0;
      bistMark <= 1'b0;
    end else begin
      bistMark <= (passCnt == LAST);
      passCnt  <= (passCnt == LAST) ? '0 : passCnt + 1'b1;
    end
  end

  // Sticky buffer fault: a new fault wins over a same-cycle sync
  always_ff @(posedge clk) begin
    if (!rstN)         faultHeld <= 1'b0;
    else if (bufFault) faultHeld <= 1'b1;
    else if (syncSent) faultHeld <= 1'b0;
  end

  assign ctl.bistMark  = bistMark;
  assign ctl.faultHeld = faultHeld;
endmodule

// File: rtl/txpgDatapath.sv
module txpgDatapath
  import txpg_pkg::*;
#(
  parameter int                DATA_W   = 10,
  parameter logic [DATA_W-1:0] ERR_CODE = 10'b1001111000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              parityEn,
  input  logic [DATA_W-1:0] inData,
  input  logic              inParity,
  input  ctlStrobes_t       ctl,
  output logic [DATA_W-1:0] outChar,
  output logic              errStatus
);
  logic badChar;
  logic parErr;

  // Odd parity over data plus parity bit; an even count is an error
  assign badChar = parityEn && !(^{inData, inParity});

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outChar <= '0;
      parErr  <= 1'b0;
    end else begin
      outChar <= badChar ? ERR_CODE : inData;
      parErr  <= badChar;
    end
  end

  assign errStatus = parErr | ctl.bistMark | ctl.faultHeld;
endmodule

// File: rtl/txParityGuard.sv
module txParityGuard
  import txpg_pkg::*;
#(
  parameter int                DATA_W   = 10,
  parameter logic [DATA_W-1:0] ERR_CODE = 10'b1001111000,
  parameter int                BIST_LEN = 511
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] inData,
  input  logic              inParity,
  input  logic              parityEn,
  input  logic              bistEn,
  input  logic              bufFault,
  input  logic              syncSent,
  output logic [DATA_W-1:0] outChar,
  output logic              errStatus
);
  ctlStrobes_t ctlBus;

  txpgCtrl #(.BIST_LEN(BIST_LEN)) u_ctrl (
    .clk(clk), .rstN(rstN), .bistEn(bistEn),
    .bufFault(bufFault), .syncSent(syncSent), .ctl(ctlBus)
  );

  txpgDatapath #(.DATA_W(DATA_W), .ERR_CODE(ERR_CODE)) u_dp (
    .clk(clk), .rstN(rstN), .parityEn(parityEn),
    .inData(inData), .inParity(inParity), .ctl(ctlBus),
    .outChar(outChar), .errStatus(errStatus)
  );
endmodule

// File: rtl/txpgChecker.sv
module txpgChecker
  import txpg_pkg::*;
#(
  parameter int                DATA_W   = 10,
  parameter logic [DATA_W-1:0] ERR_CODE = 10'b1001111000
) (
  input logic              clk,
  input logic              rstN,
  input logic [DATA_W-1:0] inData,
  input logic              inParity,
  input logic              parityEn,
  input logic              bistEn,
  input logic              bufFault,
  input logic              syncSent,
  input logic [DATA_W-1:0] outChar,
  input logic              errStatus,
  input ctlStrobes_t       ctlBus
);
  p_good_pass_r2: assert property (@(posedge clk) disable iff (!rstN)
    (parityEn && (^{inData, inParity})) |=> outChar == $past(inData));

  p_bad_replaced_r3: assert property (@(posedge clk) disable iff (!rstN)
    (parityEn && !(^{inData, inParity})) |=> (outChar == ERR_CODE && errStatus));

  p_disabled_pass_r5: assert property (@(posedge clk) disable iff (!rstN)
    !parityEn |=> outChar == $past(inData));

  p_bist_off_r6: assert property (@(posedge clk) disable iff (!rstN)
    !bistEn |=> !ctlBus.bistMark);

  p_fault_sets_r7: assert property (@(posedge clk) disable iff (!rstN)
    bufFault |=> (ctlBus.faultHeld && errStatus));

  p_fault_holds_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ctlBus.faultHeld && !syncSent) |=> ctlBus.faultHeld);

  p_fault_clears_r7: assert property (@(posedge clk) disable iff (!rstN)
    (syncSent && !bufFault) |=> !ctlBus.faultHeld);

  p_status_or_r9: assert property (@(posedge clk) disable iff (!rstN)
    (ctlBus.bistMark || ctlBus.faultHeld) |-> errStatus);
endmodule

bind txParityGuard txpgChecker #(.DATA_W(DATA_W), .ERR_CODE(ERR_CODE)) u_chk (.*);

// File: tb/sim_txParityGuard.sv
`timescale 1ns/1ps
module sim_txParityGuard;
  localparam logic [9:0] ERR = 10'b1001111000;
  localparam int BLEN = 511;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [9:0] inData = '0;
  logic       inParity = 1'b0, parityEn = 1'b0, bistEn = 1'b0;
  logic       bufFault = 1'b0, syncSent = 1'b0;
  logic [9:0] outChar;
  logic       errStatus;

  int nChecks = 0, nFails = 0;
  // bench reference state
  int  mCnt = 0;
  bit  mSticky = 0;
  bit  mBist = 0, mPar = 0;
  logic [9:0] mChar = '0;
  int  bistPulses = 0;

  always #2.5 clk = ~clk;

  txParityGuard u0 (.*);

  function automatic bit isBad(bit en, logic [9:0] d, logic p);
    return en && !(^{d, p});
  endfunction

  function automatic logic oddBit(logic [9:0] d);
    return ~(^d);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Drive at negedge, update reference at posedge, compare just after
  task automatic step(logic r, logic [9:0] d, logic p, logic pe, logic be,
                      logic bf, logic ss);
    string tg;
    @(negedge clk);
    rstN = r; inData = d; inParity = p; parityEn = pe;
    bistEn = be; bufFault = bf; syncSent = ss;
    @(posedge clk);
    if (!r) begin
      mChar = '0; mPar = 0; mBist = 0; mCnt = 0; mSticky = 0;
    end else begin
      mPar  = isBad(pe, d, p);
      mChar = mPar ? ERR : d;
      if (!be) begin mBist = 0; mCnt = 0; end
      else begin
        mBist = (mCnt == BLEN - 1);
        mCnt  = (mCnt == BLEN - 1) ? 0 : mCnt + 1;
      end
      if (bf) mSticky = 1; else if (ss) mSticky = 0;
    end
    #1;
    if (!r) tg = "R1";
    else if (mPar) tg = "R3";
    else if (!pe) tg = "R5";
    else tg = "R2";
    check({tg, " outChar"}, 32'(outChar), 32'(mChar));
    if (!r) tg = "R1";
    else if (mBist) tg = "R6";
    else if (mSticky) tg = "R7";
    else if (mPar) tg = "R4";
    else tg = "R9";
    check({tg, " errStatus"}, 32'(errStatus), 32'(mPar | mBist | mSticky));
    if (errStatus && mBist) bistPulses++;
  endtask

  initial begin
    #(200000 * 5);
    nFails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    int unused = $urandom(32'h5eed1234);
    // R1 reset state
    step(0, 10'h3ff, 0, 1, 1, 1, 0);
    step(0, 10'h155, 1, 1, 0, 0, 0);
    // R2 good parity, R3 bad parity, R4 single-cycle pulse
    step(1, 10'h000, 1, 1, 0, 0, 0);
    step(1, 10'h000, 0, 1, 0, 0, 0);
    step(1, 10'h3ff, 0, 1, 0, 0, 0);
    step(1, 10'h3ff, 1, 1, 0, 0, 0);
    step(1, 10'h001, 0, 1, 0, 0, 0);
    // R5 parity disabled with wrong parity
    step(1, 10'h2aa, ~oddBit(10'h2aa), 0, 0, 0, 0);
    step(1, 10'h0f0, 1, 0, 0, 0, 0);
    // R7 fault set, hold, clear by sync
    step(1, 10'h011, oddBit(10'h011), 1, 0, 1, 0);
    step(1, 10'h012, oddBit(10'h012), 1, 0, 0, 0);
    step(1, 10'h013, oddBit(10'h013), 1, 0, 0, 0);
    step(1, 10'h014, oddBit(10'h014), 1, 0, 0, 1);
    step(1, 10'h015, oddBit(10'h015), 1, 0, 0, 0);
    // R8 fault and sync together keeps the fault
    step(1, 10'h016, oddBit(10'h016), 1, 0, 1, 1);
    step(1, 10'h017, oddBit(10'h017), 1, 0, 0, 0);
    // R1 reset clears held fault
    step(0, 10'h018, 0, 1, 0, 0, 0);
    step(1, 10'h019, oddBit(10'h019), 1, 0, 0, 0);
    // R6 self-test: two full passes plus restart
    bistPulses = 0;
    for (int i = 0; i < 2 * BLEN + 20; i++) begin
      logic [9:0] d = 10'($urandom);
      step(1, d, oddBit(d), 1, 1, 0, 0);
    end
    check("R6 pulse count", 32'(bistPulses), 32'd2);
    step(1, 10'h0, 1, 1, 0, 0, 0);
    for (int i = 0; i < BLEN - 1; i++) step(1, 10'h1, 0, 1, 1, 0, 0);
    check("R6 restart no early pulse", 32'(bistPulses), 32'd2);
    step(1, 10'h1, 0, 1, 1, 0, 0);
    check("R6 pulse after restart", 32'(bistPulses), 32'd3);
    // random mix for R2..R9
    for (int i = 0; i < 4000; i++) begin
      logic [9:0] d = 10'($urandom);
      logic p = ($urandom % 4 == 0) ? ~oddBit(d) : oddBit(d);
      step(($urandom % 200) != 0, d, p, ($urandom % 5) != 0,
           ($urandom % 3) == 0, ($urandom % 40) == 0, ($urandom % 15) == 0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule